// File: doc/BRIEF.md
# Multiplexed ADC Frame Sequencer

This block paces a repeating input-multiplexer frame for a shared analog converter. A fast system clock runs the logic, and a one-cycle `slow_tick` strobe marks each period of the slower sample clock. A frame holds a programmable number of conversion slots. Each slot lasts a whole number of sample periods, chosen by a filter-length code. One recovery (settle) period follows the last slot.

From this frame the block derives several outputs. `pass_start` launches a compute pass when slot 0 begins. `conv_done` is a per-slot completion strobe carrying the slot index. A RAM write port stores the converter result of each slot. `xfer_busy` is a fixed-length busy window that opens once every programmed number of passes.

The slot count and the filter code are sampled only at frame boundaries, so a change made mid-frame cannot tear the frame in progress. A slot count of zero parks the sequencer.

Top module: `mux_frame_seq`

## Requirements
- R1: With N = `slot_cfg` (nonzero) and filter code c in 0..2, one slot lasts k = c+1 ticks. Successive `pass_start` pulses are exactly 1 + N×k ticks apart.
- R2: Filter code 3 is reserved and behaves exactly like code 2 (k = 3).
- R3: Counting the frame-start tick as position 0, `conv_done` pulses on the ticks at positions k, 2k, …, N×k. `conv_slot` then carries 0, 1, …, N−1 in ascending order.
- R4: With every `conv_done`, `ram_we` pulses. `ram_addr` then equals RAM_BASE + slot index, and `ram_wdata` equals the `conv_data` value present on that tick.
- R5: `frame_sync` is high from the tick completing the last slot (position N×k) until the next frame-start tick. This is exactly one settle period.
- R6: After reset, the first tick seen with a nonzero `slot_cfg` starts a frame. `pass_start` is a single fast-clock pulse.
- R7: While the sampled slot count is zero, no `pass_start`, `conv_done` or `ram_we` pulse occurs and `frame_sync` stays low. A later tick with a nonzero count restarts framing.
- R8: Changes to `slot_cfg` or `filt_code` take effect only at the next frame-start tick.
- R9: `xfer_busy` rises together with every (PRESAMPS×SUM_CYCLES)-th `pass_start`. It stays high for CE_CYCLES + floor((CE_CYCLES+2)/4) fast clocks.
- R10: During and right after reset, all pulses, `frame_sync` and `xfer_busy` are low.
- R11: Every output pulse appears in the fast cycle right after the edge that sampled `slow_tick`. Without a tick, no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle strobe per sample-clock period |
| slot_cfg | input | NW | Slots per frame; 0 parks the sequencer |
| filt_code | input | 2 | Filter-length code, slot length = code+1 ticks (3 acts as 2) |
| conv_data | input | DW | Converter result, sampled on a slot-completing tick |
| pass_start | output | 1 | Compute pass launch pulse at slot 0 start |
| frame_sync | output | 1 | High during the settle period |
| conv_done | output | 1 | Slot conversion complete pulse |
| conv_slot | output | NW | Index of the completed slot |
| ram_we | output | 1 | Result write strobe |
| ram_addr | output | AW | Result write address |
| ram_wdata | output | DW | Result write data |
| xfer_busy | output | 1 | Periodic transfer busy window |

## Verification
Every pulse output, and each edge of `frame_sync`, is due one fast clock after the edge that samples `slow_tick`. The bench therefore raises the tick on a falling edge, drops it on the next falling edge, and reads the outputs at that moment. It then runs one idle fast cycle in which all pulses must be low.

Expected positions of the pulses come from the tick count modulo 1 + N×k. The bench sweeps every slot count from 0 to 5 against all four filter codes.

`xfer_busy` follows the same one-cycle latency. Its width is measured by counting the falling edges at which it is high while ticks are withheld.

// File: rtl/mux_seq_pkg.sv
package mux_seq_pkg;

   typedef enum logic [1:0] {
      FILT_SHORT = 2'd0,
      FILT_MID   = 2'd1,
      FILT_LONG  = 2'd2,
      FILT_RSVD  = 2'd3
   } filt_code_e;

   // last sub-period index inside one slot (slot length minus one)
   function automatic logic [1:0] slot_last_sub(input logic [1:0] code);
      case (filt_code_e'(code))
         FILT_SHORT: return 2'd0;
         FILT_MID:   return 2'd1;
         default:    return 2'd2;   // long and reserved codes share length 3
      endcase
   endfunction

endpackage

// File: rtl/mux_slot_walker.sv
module mux_slot_walker
   import mux_seq_pkg::*;
#(
   parameter int NW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic [NW-1:0] cfg_slots,
   input  logic [1:0]    cfg_code,
   output logic          evt_start,
   output logic          evt_done,
   output logic [NW-1:0] done_slot,
   output logic          settle
);

   localparam logic [NW-1:0] SLOT_ONE = NW'(1);

   logic          active_q;
   logic          settle_q;
   logic [NW-1:0] slot_q;
   logic [NW-1:0] nslots_q;
   logic [1:0]    sub_q;
   logic [1:0]    sub_max_q;

   logic boundary;
   logic evt_last;
   logic running;

   always_comb begin
      running   = active_q && !settle_q;
      boundary  = tick && (!active_q || settle_q);
      evt_start = boundary && (cfg_slots != '0);
      evt_done  = tick && running && (sub_q == sub_max_q);
      evt_last  = evt_done && ((slot_q + SLOT_ONE) == nslots_q);
      done_slot = slot_q;
      settle    = settle_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q  <= 1'b0;
         settle_q  <= 1'b0;
         slot_q    <= '0;
         nslots_q  <= '0;
         sub_q     <= '0;
         sub_max_q <= '0;
      end else if (boundary) begin
         active_q  <= (cfg_slots != '0);
         settle_q  <= 1'b0;
         slot_q    <= '0;
         sub_q     <= '0;
         nslots_q  <= cfg_slots;
         sub_max_q <= slot_last_sub(cfg_code);
      end else if (evt_done) begin
         sub_q <= '0;
         if (evt_last) begin
            settle_q <= 1'b1;
         end else begin
            slot_q <= slot_q + SLOT_ONE;
         end
      end else if (tick && running) begin
         sub_q <= sub_q + 2'd1;
      end
   end

endmodule

// File: rtl/mux_result_reg.sv
module mux_result_reg #(
   parameter int NW        = 4,
   parameter int DW        = 16,
   parameter int AW        = 8,
   parameter int RAM_BASE  = 32,
   parameter bit HOLD_DATA = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          evt_done,
   input  logic [NW-1:0] slot,
   input  logic [DW-1:0] data,
   output logic          conv_done,
   output logic [NW-1:0] conv_slot,
   output logic          ram_we,
   output logic [AW-1:0] ram_addr,
   output logic [DW-1:0] ram_wdata
);

   localparam logic [AW-1:0] BASE_ADDR = AW'(RAM_BASE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conv_done <= 1'b0;
         ram_we    <= 1'b0;
         conv_slot <= '0;
         ram_addr  <= '0;
      end else begin
         conv_done <= evt_done;
         ram_we    <= evt_done;
         if (evt_done) begin
            conv_slot <= slot;
            ram_addr  <= BASE_ADDR + AW'(slot);
         end
      end
   end

   generate
      if (HOLD_DATA) begin : g_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        ram_wdata <= '0;
            else if (evt_done) ram_wdata <= data;
         end
      end else begin : g_zero
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ram_wdata <= '0;
            else        ram_wdata <= evt_done ? data : '0;
         end
      end
   endgenerate

endmodule

// File: rtl/mux_xfer_window.sv
module mux_xfer_window #(
   parameter int PASS_PERIOD = 6,
   parameter int BUSY_LEN    = 13
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pass_evt,
   output logic busy
);

   localparam int BW = $clog2(BUSY_LEN + 1);
   localparam logic [BW-1:0] BUSY_LOAD = BW'(BUSY_LEN);

   logic          fire;
   logic [BW-1:0] busy_q;

   generate
      if (PASS_PERIOD == 1) begin : g_every
         always_comb fire = pass_evt;
      end else begin : g_count
         localparam int PW = $clog2(PASS_PERIOD);
         localparam logic [PW-1:0] PASS_LAST = PW'(PASS_PERIOD - 1);
         logic [PW-1:0] pass_q;
         always_comb fire = pass_evt && (pass_q == PASS_LAST);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        pass_q <= '0;
            else if (fire)     pass_q <= '0;
            else if (pass_evt) pass_q <= pass_q + PW'(1);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            busy_q <= '0;
      else if (fire)         busy_q <= BUSY_LOAD;
      else if (busy_q != '0) busy_q <= busy_q - BW'(1);
   end

   always_comb busy = (busy_q != '0);

endmodule

// File: rtl/mux_frame_seq.sv
module mux_frame_seq
   import mux_seq_pkg::*;
#(
   parameter int NW         = 4,
   parameter int DW         = 16,
   parameter int AW         = 8,
   parameter int RAM_BASE   = 32,
   parameter int PRESAMPS   = 2,
   parameter int SUM_CYCLES = 3,
   parameter int CE_CYCLES  = 10,
   parameter bit HOLD_DATA  = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          slow_tick,
   input  logic [NW-1:0] slot_cfg,
   input  logic [1:0]    filt_code,
   input  logic [DW-1:0] conv_data,
   output logic          pass_start,
   output logic          frame_sync,
   output logic          conv_done,
   output logic [NW-1:0] conv_slot,
   output logic          ram_we,
   output logic [AW-1:0] ram_addr,
   output logic [DW-1:0] ram_wdata,
   output logic          xfer_busy
);

   localparam int PASS_PERIOD = PRESAMPS * SUM_CYCLES;
   localparam int BUSY_LEN    = CE_CYCLES + (CE_CYCLES + 2) / 4;

   generate
      if (NW < 1 || DW < 1 || AW < 1) begin : g_bad_width
         $error("mux_frame_seq: widths must be positive");
      end
      if (PRESAMPS < 1 || SUM_CYCLES < 1) begin : g_bad_period
         $error("mux_frame_seq: pass period factors must be positive");
      end
      if (CE_CYCLES < 1) begin : g_bad_busy
         $error("mux_frame_seq: busy length must be positive");
      end
      if (RAM_BASE < 0 || (RAM_BASE + (1 << NW) - 1) >= (1 << AW)) begin : g_bad_addr
         $error("mux_frame_seq: result area exceeds address range");
      end
   endgenerate

   logic          evt_start;
   logic          evt_done;
   logic [NW-1:0] done_slot;
   logic          settle;

   mux_slot_walker #(.NW(NW)) u_walker (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (slow_tick),
      .cfg_slots (slot_cfg),
      .cfg_code  (filt_code),
      .evt_start (evt_start),
      .evt_done  (evt_done),
      .done_slot (done_slot),
      .settle    (settle)
   );

   mux_result_reg #(
      .NW(NW), .DW(DW), .AW(AW), .RAM_BASE(RAM_BASE), .HOLD_DATA(HOLD_DATA)
   ) u_result (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_done  (evt_done),
      .slot      (done_slot),
      .data      (conv_data),
      .conv_done (conv_done),
      .conv_slot (conv_slot),
      .ram_we    (ram_we),
      .ram_addr  (ram_addr),
      .ram_wdata (ram_wdata)
   );

   mux_xfer_window #(
      .PASS_PERIOD(PASS_PERIOD), .BUSY_LEN(BUSY_LEN)
   ) u_xfer (
      .clk      (clk),
      .rst_n    (rst_n),
      .pass_evt (evt_start),
      .busy     (xfer_busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pass_start <= 1'b0;
      else        pass_start <= evt_start;
   end

   always_comb frame_sync = settle;

endmodule

// File: rtl/mux_frame_seq_chk.sv
module mux_frame_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic slow_tick,
   input logic pass_start,
   input logic frame_sync,
   input logic conv_done,
   input logic ram_we,
   input logic xfer_busy
);

   // R3
   start_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pass_start && conv_done));

   // R5
   settle_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_sync) |-> conv_done);

   // R6
   start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pass_start |=> !pass_start);

   // R11
   no_tick_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(slow_tick) |-> (!pass_start && !conv_done && !ram_we && $stable(frame_sync)));

   // R9
   busy_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(xfer_busy) |-> pass_start);

endmodule

bind mux_frame_seq mux_frame_seq_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .slow_tick  (slow_tick),
   .pass_start (pass_start),
   .frame_sync (frame_sync),
   .conv_done  (conv_done),
   .ram_we     (ram_we),
   .xfer_busy  (xfer_busy)
);

// File: tb/test_mux_frame_seq.sv
`timescale 1ns/1ps
module test_mux_frame_seq;

   localparam int NW = 4;
   localparam int DW = 16;
   localparam int AW = 8;
   localparam int RAM_BASE = 32;
   localparam int PERIOD = 2 * 3;
   localparam int BUSYW = 10 + (10 + 2) / 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          slow_tick = 1'b0;
   logic [NW-1:0] slot_cfg = '0;
   logic [1:0]    filt_code = '0;
   logic [DW-1:0] conv_data = '0;
   logic          pass_start, frame_sync, conv_done, ram_we, xfer_busy;
   logic [NW-1:0] conv_slot;
   logic [AW-1:0] ram_addr;
   logic [DW-1:0] ram_wdata;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   mux_frame_seq i_mux_frame_seq (
      .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .slot_cfg(slot_cfg),
      .filt_code(filt_code), .conv_data(conv_data), .pass_start(pass_start),
      .frame_sync(frame_sync), .conv_done(conv_done), .conv_slot(conv_slot),
      .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
      .xfer_busy(xfer_busy)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk);
      chk("R10 pulses", {29'd0, pass_start, conv_done, ram_we}, 32'd0);
      chk("R10 levels", {30'd0, frame_sync, xfer_busy}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // raise the tick for one fast cycle; outputs are read one edge later
   task automatic tick(input logic [DW-1:0] d);
      @(negedge clk) slow_tick = 1'b1; conv_data = d;
      @(negedge clk) slow_tick = 1'b0;
   endtask

   task automatic idle_check();
      @(negedge clk);
      chk("R11 idle", {30'd0, pass_start, conv_done}, 32'd0);
   endtask

   task automatic run_cfg(input int n, input int code);
      int k, len, pos, nt;
      string rq;
      k   = (code == 3) ? 3 : code + 1;
      len = n * k + 1;
      rq  = (code == 3) ? "R2" : "R1";
      slot_cfg  = NW'(n);
      filt_code = 2'(code);
      do_reset();
      nt = (n == 0) ? 8 : 2 * len;
      for (int j = 0; j < nt; j++) begin
         logic [DW-1:0] d;
         d = DW'(j * 37 + n * 5 + code + 1);
         tick(d);
         if (n == 0) begin
            chk("R7 quiet", {29'd0, pass_start, conv_done, frame_sync}, 32'd0);
         end else begin
            pos = j % len;
            if (j == 0) chk("R6 first start", pass_start, 1);
            else        chk(rq, pass_start, (pos == 0));
            chk("R5 settle", frame_sync, (pos == n * k));
            chk("R3 done", conv_done, (pos >= k && pos % k == 0));
            if (pos >= k && pos % k == 0) begin
               chk("R3 slot", conv_slot, pos / k - 1);
               chk("R4 we", ram_we, 1);
               chk("R4 addr", ram_addr, RAM_BASE + pos / k - 1);
               chk("R4 data", ram_wdata, d);
            end
         end
         idle_check();
      end
   endtask

   initial begin
      #(4 * 200000);
      fails++;
      $display("FAIL R6 watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      // sweep slot counts against all filter codes
      for (int n = 0; n <= 5; n++)
         for (int c = 0; c < 4; c++)
            run_cfg(n, c);

      // R8: mid-frame change waits for the boundary
      slot_cfg = 4'd2; filt_code = 2'd0;
      do_reset();
      tick(16'h0);
      chk("R8 start", pass_start, 1);
      slot_cfg = 4'd3; filt_code = 2'd1;
      for (int j = 1; j <= 11; j++) begin
         tick(16'(j));
         chk("R8 start pos", pass_start, (j == 3 || j == 10));
         chk("R8 done pos", conv_done, (j == 1 || j == 2 || j == 5 || j == 7 || j == 9));
      end

      // R7: zero count at boundary parks, nonzero resumes
      slot_cfg = 4'd1; filt_code = 2'd0;
      do_reset();
      tick(16'h0);
      slot_cfg = 4'd0;
      tick(16'h1);
      chk("R7 last done", conv_done, 1);
      for (int j = 0; j < 4; j++) begin
         tick(16'h2);
         chk("R7 parked", {30'd0, pass_start, frame_sync}, 32'd0);
      end
      slot_cfg = 4'd1;
      tick(16'h3);
      chk("R7 resume", pass_start, 1);

      // R9: busy window every PERIOD passes
      slot_cfg = 4'd1; filt_code = 2'd0;
      do_reset();
      for (int j = 0; j <= 22; j++) begin
         tick(16'(j));
         if (j == 2 * (PERIOD - 1) || j == 2 * (2 * PERIOD - 1)) begin
            int cnt;
            chk("R9 rise", xfer_busy, 1);
            cnt = 1;
            for (int w = 0; w < 100; w++) begin
               @(negedge clk);
               if (!xfer_busy) break;
               cnt++;
            end
            chk("R9 width", cnt, BUSYW);
         end else if (j > 2 * (PERIOD - 1) + 1 || j < 2 * (PERIOD - 1)) begin
            chk("R9 low", xfer_busy, 0);
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule